// File: doc/BRIEF.md
# Enable-Pin Rail Sequencer

This block turns three supply rails on and off: two step-down converters and one step-up converter. Each rail takes its on/off request from one of two places. The first is its own register enable bit. The second is one of three external enable pins. When a pin drives a rail, the rail waits a programmable start delay after the pin goes high and a programmable stop delay after it goes low. A register-driven rail switches at once.

Once a rail is enabled, the block watches that rail's threshold-reached input. If the input does not arrive within 1 ms, the block treats the rail as shorted. It drops the rail and raises a sticky flag for it. A watchdog restart request makes every pin-driven rail whose pin is high run its stop delay and then its start delay. A software reset, or the device reset input going low, drops every rail with no delay. A one-cycle done pulse marks the point where all pin-driven rails have settled. The converters' analog soft start is outside the block: it only drives rail enables and reads the threshold bits.

Each rail runs its own state machine with six states:
- **OFF**: the rail is off.
- **UP_WAIT**: the start delay is counting and the rail is still off.
- **RAMP**: the rail is enabled and the timeout is counting until the threshold is reached.
- **ON**: the threshold has been reached.
- **DN_WAIT**: the stop delay is counting and the rail is still on.
- **FAULT**: the rail has been dropped after a timeout.

The transitions are:
- OFF→UP_WAIT: the pin is high under pin control.
- OFF→RAMP: the register bit is set under register control.
- UP_WAIT→RAMP: the start delay has expired.
- UP_WAIT→OFF: the pin is low, so the pending start is cancelled.
- RAMP→ON: the threshold bit is high.
- RAMP→FAULT: the timeout has expired.
- RAMP/ON→DN_WAIT: the pin is low, or a watchdog restart arrives.
- DN_WAIT→OFF: the stop delay has expired.
- DN_WAIT→UP_WAIT: the stop delay has expired during a restart with the pin still high.
- DN_WAIT→RAMP: the pin has gone high again, so the pending stop is cancelled.
- FAULT→OFF: the request has been removed.
- Any state→OFF: a software reset, or the register bit cleared under register control.

Top module: `rail_sequencer`

## Requirements
- R1: A rail's 2-bit select field of 0 ties it to its register bit. Values 1, 2 and 3 tie it to `en_pin[0]`, `en_pin[1]` and `en_pin[2]`. The other pins have no effect on that rail.
- R2: Pin control applies only when the register bit is 1 and the select field is nonzero. A rail whose register bit is 0 turns off at the next clock edge and stays off whatever its pin does.
- R3: Under pin control, the rail enable rises exactly 4 + code×unit clock edges after the first edge that follows the pin rising. Here code is the rail's 4-bit start code, and the 4 includes a 2-flop pin synchronizer.
- R4: Under pin control, the rail enable falls exactly 4 + code×unit clock edges after the first edge that follows the pin falling. Here code is the rail's 4-bit stop code.
- R5: The unit is HALF_MS_CYC clock cycles (0.5 ms) when `dly_unit_sel` is 0, and 2×HALF_MS_CYC clock cycles (1 ms) when it is 1.
- R6: Under register control, setting or clearing the register bit changes the rail enable at the very next clock edge, whatever the delay codes hold.
- R7: If the threshold bit is still low 2×HALF_MS_CYC clock edges after the rail enable rises, the rail drops and its `rail_sc` bit is set. The rail stays off until its request is removed, and the flag stays set after the rail restarts. A threshold that arrives one edge before the limit avoids the fault.
- R8: `sw_reset` high at a clock edge clears every rail enable and every `rail_sc` bit at that edge. `rst_n` low clears them at once, without waiting for a clock edge.
- R9: A one-cycle `wd_restart` makes each pin-controlled rail whose pin is high and whose threshold is reached do the following: stay on for stop-code×unit + 1 edges, drop, and rise again start-code×unit + 1 edges later. Register-controlled rails and rails whose pin is low are unaffected.
- R10: If the pin reverses while a delay is counting, the pending action is cancelled: a pending start never turns the rail on, and a pending stop never turns it off.
- R11: `seq_done` is high for exactly one cycle when every pin-controlled rail has reached its requested state. A rail has reached it when it is ON (or FAULT) with its pin high, or OFF (or FAULT) with its pin low. The pulse appears in the cycle that state is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Device reset, active low, asynchronous |
| sw_reset | input | 1 | Software reset, synchronous |
| wd_restart | input | 1 | Watchdog restart request, one-cycle pulse |
| en_pin | input | NUM_PINS | External enable pins, asynchronous |
| dly_unit_sel | input | 1 | Delay step: 0 = 0.5 ms, 1 = 1 ms |
| rail_reg_en | input | NUM_RAILS | Register enable bit per rail |
| rail_pin_sel | input | NUM_RAILS*SEL_W | Select field per rail (rail r at bits r*SEL_W) |
| rail_up_dly | input | NUM_RAILS*DLY_W | Start delay code per rail |
| rail_dn_dly | input | NUM_RAILS*DLY_W | Stop delay code per rail |
| rail_pg | input | NUM_RAILS | Threshold-reached bit per rail, synchronous |
| rail_en | output | NUM_RAILS | Rail enable outputs |
| rail_sc | output | NUM_RAILS | Sticky short-circuit flags |
| seq_done | output | 1 | One-cycle settle pulse |

## Verification
The bench builds the block with HALF_MS_CYC = 4, so one delay step is 4 or 8 cycles and the timeout is 8 cycles. At that size every start and stop code from 0 to 15 can be swept on every rail, through every pin, at both step sizes, and each edge is checked on the exact cycle. The short timeout lets the bench place the threshold arrival on both sides of the limit. The small counts also let the watchdog restart and the mid-delay reversals be timed cycle by cycle in a short run.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;
    typedef enum logic [2:0] {
        RS_OFF     = 3'd0,
        RS_UP_WAIT = 3'd1,
        RS_RAMP    = 3'd2,
        RS_ON      = 3'd3,
        RS_DN_WAIT = 3'd4,
        RS_FAULT   = 3'd5
    } rail_state_t;
endpackage

// File: rtl/seq_pin_sync.sv
module seq_pin_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            d_sync <= '0;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end
endmodule

// File: rtl/seq_rail_fsm.sv
module seq_rail_fsm
    import rail_seq_pkg::*;
#(
    parameter int NUM_PINS    = 3,
    parameter int SEL_W       = 2,
    parameter int DLY_W       = 4,
    parameter int HALF_MS_CYC = 50000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_reset,
    input  logic                wd_restart,
    input  logic                reg_en,
    input  logic [SEL_W-1:0]    pin_sel,
    input  logic [NUM_PINS-1:0] pins_s,
    input  logic                unit_sel,
    input  logic [DLY_W-1:0]    up_code,
    input  logic [DLY_W-1:0]    dn_code,
    input  logic                pg,
    output logic                rail_en,
    output logic                sc_flag,
    output logic                settled
);
    localparam int MAX_CNT = ((1 << DLY_W) - 1) * 2 * HALF_MS_CYC;
    localparam int CW      = $clog2(MAX_CNT + 1);
    localparam logic [CW-1:0] HALF_W = CW'(HALF_MS_CYC);
    localparam logic [CW-1:0] FULL_W = CW'(2 * HALF_MS_CYC);
    localparam logic [CW-1:0] TMO_W  = CW'(2 * HALF_MS_CYC - 1);

    rail_state_t   st, nxt;
    logic [CW-1:0] cnt, ncnt;
    logic          pend, npend;
    logic          nflag;
    logic          pin_mode, pin_lvl;
    logic [CW-1:0] unit_w, up_load, dn_load;

    always_comb begin
        pin_lvl = 1'b0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (pin_sel == SEL_W'(i + 1)) pin_lvl = pins_s[i];
        end
    end

    assign pin_mode = reg_en && (pin_sel != '0);
    assign unit_w   = unit_sel ? FULL_W : HALF_W;
    assign up_load  = CW'(up_code) * unit_w;
    assign dn_load  = CW'(dn_code) * unit_w;

    // next-state logic
    always_comb begin
        nxt   = st;
        ncnt  = cnt;
        npend = pend;
        nflag = sc_flag;
        if (sw_reset) begin
            nxt   = RS_OFF;
            ncnt  = '0;
            npend = 1'b0;
            nflag = 1'b0;
        end else if (!pin_mode) begin
            npend = 1'b0;
            if (!reg_en) begin
                nxt = RS_OFF;
            end else begin
                unique case (st)
                    RS_OFF, RS_UP_WAIT, RS_DN_WAIT: begin
                        nxt  = RS_RAMP;
                        ncnt = TMO_W;
                    end
                    RS_RAMP: begin
                        if (pg) nxt = RS_ON;
                        else if (cnt == '0) begin
                            nxt   = RS_FAULT;
                            nflag = 1'b1;
                        end else ncnt = cnt - 1'b1;
                    end
                    RS_ON, RS_FAULT: nxt = st;
                    default: nxt = RS_OFF;
                endcase
            end
        end else begin
            unique case (st)
                RS_OFF: begin
                    if (pin_lvl) begin
                        nxt  = RS_UP_WAIT;
                        ncnt = up_load;
                    end
                end
                RS_UP_WAIT: begin
                    if (!pin_lvl) begin
                        nxt   = RS_OFF;
                        npend = 1'b0;
                    end else if (cnt == '0) begin
                        nxt  = RS_RAMP;
                        ncnt = TMO_W;
                    end else ncnt = cnt - 1'b1;
                end
                RS_RAMP: begin
                    if (!pin_lvl || wd_restart) begin
                        nxt   = RS_DN_WAIT;
                        ncnt  = dn_load;
                        npend = pin_lvl;
                    end else if (pg) nxt = RS_ON;
                    else if (cnt == '0) begin
                        nxt   = RS_FAULT;
                        nflag = 1'b1;
                    end else ncnt = cnt - 1'b1;
                end
                RS_ON: begin
                    if (!pin_lvl || wd_restart) begin
                        nxt   = RS_DN_WAIT;
                        ncnt  = dn_load;
                        npend = pin_lvl;
                    end
                end
                RS_DN_WAIT: begin
                    if (pin_lvl && !pend) begin
                        nxt  = RS_RAMP;
                        ncnt = TMO_W;
                    end else if (cnt == '0) begin
                        npend = 1'b0;
                        if (pend && pin_lvl) begin
                            nxt  = RS_UP_WAIT;
                            ncnt = up_load;
                        end else nxt = RS_OFF;
                    end else begin
                        ncnt = cnt - 1'b1;
                        if (!pin_lvl) npend = 1'b0;
                    end
                end
                RS_FAULT: begin
                    if (!pin_lvl) nxt = RS_OFF;
                end
                default: nxt = RS_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= RS_OFF;
            cnt     <= '0;
            pend    <= 1'b0;
            sc_flag <= 1'b0;
        end else begin
            st      <= nxt;
            cnt     <= ncnt;
            pend    <= npend;
            sc_flag <= nflag;
        end
    end

    // outputs
    always_comb begin
        rail_en = (st == RS_RAMP) || (st == RS_ON) || (st == RS_DN_WAIT);
        if (!pin_mode) settled = 1'b1;
        else if (pin_lvl) settled = (st == RS_ON) || (st == RS_FAULT);
        else settled = (st == RS_OFF) || (st == RS_FAULT);
    end

    a_r2_reg_clear_off: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_en |=> !rail_en);

    a_r6_reg_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_mode && reg_en && !sw_reset && st == RS_OFF) |=> rail_en);

    a_r7_flag_from_ramp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sc_flag) |-> $past(st == RS_RAMP && !pg));

    a_r8_sw_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (!rail_en && !sc_flag));

    a_r9_restart_holds_on: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_mode && pin_lvl && wd_restart && !sw_reset && st == RS_ON)
            |=> (rail_en && st == RS_DN_WAIT));
endmodule

// File: rtl/seq_done_tracker.sv
module seq_done_tracker #(
    parameter int NUM_RAILS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RAILS-1:0] settled,
    output logic                 seq_done
);
    logic all_now, all_q;

    assign all_now  = &settled;
    assign seq_done = all_now && !all_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) all_q <= 1'b1;
        else        all_q <= all_now;
    end

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer #(
    parameter int NUM_RAILS   = 3,
    parameter int NUM_PINS    = 3,
    parameter int DLY_W       = 4,
    parameter int HALF_MS_CYC = 50000,
    localparam int SEL_W      = $clog2(NUM_PINS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sw_reset,
    input  logic                       wd_restart,
    input  logic [NUM_PINS-1:0]        en_pin,
    input  logic                       dly_unit_sel,
    input  logic [NUM_RAILS-1:0]       rail_reg_en,
    input  logic [NUM_RAILS*SEL_W-1:0] rail_pin_sel,
    input  logic [NUM_RAILS*DLY_W-1:0] rail_up_dly,
    input  logic [NUM_RAILS*DLY_W-1:0] rail_dn_dly,
    input  logic [NUM_RAILS-1:0]       rail_pg,
    output logic [NUM_RAILS-1:0]       rail_en,
    output logic [NUM_RAILS-1:0]       rail_sc,
    output logic                       seq_done
);
    logic [NUM_PINS-1:0]  pins_s;
    logic [NUM_RAILS-1:0] settled;

    seq_pin_sync #(.W(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (en_pin),
        .d_sync  (pins_s)
    );

    for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
        seq_rail_fsm #(
            .NUM_PINS    (NUM_PINS),
            .SEL_W       (SEL_W),
            .DLY_W       (DLY_W),
            .HALF_MS_CYC (HALF_MS_CYC)
        ) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .sw_reset   (sw_reset),
            .wd_restart (wd_restart),
            .reg_en     (rail_reg_en[r]),
            .pin_sel    (rail_pin_sel[r*SEL_W +: SEL_W]),
            .pins_s     (pins_s),
            .unit_sel   (dly_unit_sel),
            .up_code    (rail_up_dly[r*DLY_W +: DLY_W]),
            .dn_code    (rail_dn_dly[r*DLY_W +: DLY_W]),
            .pg         (rail_pg[r]),
            .rail_en    (rail_en[r]),
            .sc_flag    (rail_sc[r]),
            .settled    (settled[r])
        );
    end

    seq_done_tracker #(.NUM_RAILS(NUM_RAILS)) u_done (
        .clk      (clk),
        .rst_n    (rst_n),
        .settled  (settled),
        .seq_done (seq_done)
    );
endmodule

// File: tb/rail_sequencer_tb.sv
module rail_sequencer_tb;
    localparam int NR = 3;
    localparam int NP = 3;
    localparam int DW = 4;
    localparam int H  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sw_reset = 1'b0;
    logic          wd_restart = 1'b0;
    logic [NP-1:0] en_pin = '0;
    logic          unit_sel = 1'b0;
    logic [NR-1:0] reg_en = '0;
    logic [NR*2-1:0]  pin_sel = '0;
    logic [NR*DW-1:0] up_dly = '0;
    logic [NR*DW-1:0] dn_dly = '0;
    logic [NR-1:0] pg = '1;
    logic [NR-1:0] rail_en, rail_sc;
    logic          seq_done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rail_sequencer #(
        .NUM_RAILS(NR), .NUM_PINS(NP), .DLY_W(DW), .HALF_MS_CYC(H)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .wd_restart(wd_restart),
        .en_pin(en_pin), .dly_unit_sel(unit_sel), .rail_reg_en(reg_en),
        .rail_pin_sel(pin_sel), .rail_up_dly(up_dly), .rail_dn_dly(dn_dly),
        .rail_pg(pg), .rail_en(rail_en), .rail_sc(rail_sc), .seq_done(seq_done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input int r, input logic en, input logic [1:0] sel,
                       input logic [3:0] up, input logic [3:0] dn);
        reg_en[r]        = en;
        pin_sel[r*2 +: 2] = sel;
        up_dly[r*DW +: DW] = up;
        dn_dly[r*DW +: DW] = dn;
    endtask

    task automatic all_off();
        for (int r = 0; r < NR; r++) cfg(r, 1'b0, 2'd0, 4'd0, 4'd0);
        en_pin = '0;
        pg = '1;
        tick(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        chk("R8 reset rail_en", int'(rail_en), 0);
        chk("R8 reset rail_sc", int'(rail_sc), 0);
        chk("R11 reset seq_done", int'(seq_done), 0);

        // R3 R4 R5 R1 R11: sweep of codes, rails, pins and both step sizes
        for (int s = 0; s < 2; s++) begin
            for (int r = 0; r < NR; r++) begin
                for (int code = 0; code < 16; code++) begin
                    int p, du, dd, unit;
                    all_off();
                    unit_sel = s[0];
                    unit = (s == 1) ? 2 * H : H;
                    p = (r + code) % NP;
                    du = code * unit;
                    dd = (15 - code) * unit;
                    cfg(r, 1'b1, 2'(p + 1), 4'(code), 4'(15 - code));
                    tick(3);
                    en_pin[p] = 1'b1;
                    tick(3 + du);
                    chk("R3 before start", int'(rail_en[r]), 0);
                    tick(1);
                    chk("R3/R5 start edge", int'(rail_en[r]), 1);
                    chk("R1 other rails idle", int'(rail_en & ~(NR'(1) << r)), 0);
                    tick(1);
                    chk("R11 pulse on", int'(seq_done), 1);
                    tick(1);
                    chk("R11 pulse ends", int'(seq_done), 0);
                    en_pin[p] = 1'b0;
                    tick(3 + dd);
                    chk("R4 before stop", int'(rail_en[r]), 1);
                    tick(1);
                    chk("R4/R5 stop edge", int'(rail_en[r]), 0);
                    chk("R11 pulse off", int'(seq_done), 1);
                end
            end
        end

        // R1: only the selected pin drives the rail
        all_off();
        unit_sel = 1'b0;
        cfg(0, 1'b1, 2'd2, 4'd0, 4'd0);
        tick(2);
        en_pin = 3'b101;
        tick(12);
        chk("R1 unselected pins", int'(rail_en[0]), 0);
        en_pin[1] = 1'b1;
        tick(4);
        chk("R1 selected pin", int'(rail_en[0]), 1);
        en_pin = '0;
        tick(6);
        chk("R1 selected pin low", int'(rail_en[0]), 0);

        // R2: register bit 0 masks the pin
        all_off();
        cfg(1, 1'b0, 2'd1, 4'd0, 4'd0);
        en_pin[0] = 1'b1;
        tick(20);
        chk("R2 pin ignored", int'(rail_en[1]), 0);
        cfg(1, 1'b1, 2'd1, 4'd0, 4'd0);
        tick(4);
        chk("R2 pin control live", int'(rail_en[1]), 1);
        reg_en[1] = 1'b0;
        tick(1);
        chk("R2 cleared at once", int'(rail_en[1]), 0);

        // R6: register control ignores delays
        all_off();
        unit_sel = 1'b1;
        for (int r = 0; r < NR; r++) begin
            cfg(r, 1'b1, 2'd0, 4'd15, 4'd15);
            tick(1);
            chk("R6 on next edge", int'(rail_en[r]), 1);
            reg_en[r] = 1'b0;
            tick(1);
            chk("R6 off next edge", int'(rail_en[r]), 0);
        end

        // R7: start-up timeout, sticky flag
        all_off();
        unit_sel = 1'b0;
        pg[2] = 1'b0;
        cfg(2, 1'b1, 2'd0, 4'd0, 4'd0);
        tick(1);
        chk("R7 rail up", int'(rail_en[2]), 1);
        tick(2 * H - 1);
        chk("R7 last cycle on", int'(rail_en[2]), 1);
        chk("R7 no flag yet", int'(rail_sc[2]), 0);
        tick(1);
        chk("R7 dropped", int'(rail_en[2]), 0);
        chk("R7 flag set", int'(rail_sc[2]), 1);
        tick(20);
        chk("R7 held off", int'(rail_en[2]), 0);
        reg_en[2] = 1'b0;
        tick(1);
        pg[2] = 1'b1;
        reg_en[2] = 1'b1;
        tick(3);
        chk("R7 restart ok", int'(rail_en[2]), 1);
        chk("R7 flag sticky", int'(rail_sc[2]), 1);
        // threshold one edge before the limit
        reg_en[2] = 1'b0;
        tick(1);
        pg[2] = 1'b0;
        reg_en[2] = 1'b1;
        tick(2 * H - 2);
        pg[2] = 1'b1;
        tick(5);
        chk("R7 late pg on", int'(rail_en[2]), 1);

        // R8: software reset clears flags and rails
        en_pin[0] = 1'b1;
        cfg(0, 1'b1, 2'd1, 4'd0, 4'd0);
        tick(6);
        chk("R8 setup rail0", int'(rail_en[0]), 1);
        sw_reset = 1'b1;
        tick(1);
        sw_reset = 1'b0;
        chk("R8 sw rails off", int'(rail_en), 0);
        chk("R8 sw flags off", int'(rail_sc), 0);
        tick(6);
        chk("R8 resume", int'(rail_en), 3'b101);
        #1 rst_n = 1'b0;
        #1;
        chk("R8 async rails off", int'(rail_en), 0);
        tick(2);
        rst_n = 1'b1;

        // R9: watchdog restart
        all_off();
        unit_sel = 1'b0;
        cfg(0, 1'b1, 2'd1, 4'd2, 4'd3);
        cfg(1, 1'b1, 2'd0, 4'd0, 4'd0);
        cfg(2, 1'b1, 2'd3, 4'd0, 4'd0);
        en_pin[0] = 1'b1;
        tick(16);
        chk("R9 setup", int'(rail_en), 3'b011);
        wd_restart = 1'b1;
        tick(1);
        wd_restart = 1'b0;
        tick(3 * H);
        chk("R9 still on", int'(rail_en), 3'b011);
        tick(1);
        chk("R9 dropped", int'(rail_en), 3'b010);
        tick(2 * H);
        chk("R9 waiting", int'(rail_en), 3'b010);
        tick(1);
        chk("R9 back on", int'(rail_en), 3'b011);

        // R10: reversal cancels pending action
        all_off();
        unit_sel = 1'b0;
        cfg(0, 1'b1, 2'd1, 4'd10, 4'd10);
        tick(2);
        en_pin[0] = 1'b1;
        tick(10);
        en_pin[0] = 1'b0;
        for (int k = 0; k < 6; k++) begin
            tick(10);
            chk("R10 start cancelled", int'(rail_en[0]), 0);
        end
        up_dly[3:0] = 4'd0;
        en_pin[0] = 1'b1;
        tick(7);
        chk("R10 setup on", int'(rail_en[0]), 1);
        en_pin[0] = 1'b0;
        tick(10);
        en_pin[0] = 1'b1;
        for (int k = 0; k < 6; k++) begin
            tick(10);
            chk("R10 stop cancelled", int'(rail_en[0]), 1);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule